// File: doc/BRIEF.md
# CPU Presence Bitmap Port

This block is a small byte-wide register window that shows which processors are present. Each processor has one bit, and the bit's position is the processor's interrupt-controller ID. Software reads the bitmap from a 32-byte window, one byte at a time. Bit 0 stands for the boot processor and is always set.

When the platform reports a hot-add, the block sets the bit for that processor. If the bit was newly set, the block also raises a one-cycle general-purpose event interrupt and a sticky event status flag. That flag stands for event bit 2. Software clears the flag by writing a one to it.

The bitmap cannot be written. A write of zero into any byte of the first 32-bit word is instead taken as a request to leave this interface for the newer hotplug register set. The block records that request in a sticky mode flag. From then on the window reads as zero.

Top module: `cpu_present_port`

## Requirements
- R1: After reset, byte offset 0 reads 0x01, every other offset reads 0x00, and `gpe_irq`, `gpe_sts` and `modern_mode` are all 0.
- R2: A read (`io_en`=1, `io_we`=0) at offset a returns presence bits 8a+7 down to 8a on `io_rdata` in the same cycle, with bit 8a+k in data bit k. When no read is in progress, `io_rdata` is 0x00.
- R3: Bit 0 of offset 0 always reads 1, and a hot-add with ID 0 raises no interrupt.
- R4: A hot-add with an ID below `NUM_CPUS` sets that ID's bit, and the bit can be read from the next cycle on. No event ever clears a set bit before reset.
- R5: A hot-add with an ID of `NUM_CPUS` or more is ignored. Bits at positions `NUM_CPUS` and above always read 0.
- R6: No write to the window changes the bitmap.
- R7: A write of 0x00 to offset 0, 1, 2 or 3 sets `modern_mode` from the next cycle on, and it stays set until reset. A write of nonzero data, or a write to an offset of 4 or more, leaves the mode unchanged.
- R8: While `modern_mode` is 1, every read of the window returns 0x00.
- R9: A hot-add that sets a bit which was clear makes `gpe_irq` high for exactly the next cycle. A hot-add of a bit that is already set, or that is ignored, leaves `gpe_irq` low.
- R10: `gpe_sts` becomes 1 in the same cycle as each `gpe_irq` pulse and stays 1. A pulse on `gpe_sts_w1c` clears it in the next cycle. If a new event and a clear arrive in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_en | input | 1 | Window access strobe |
| io_we | input | 1 | 1 = write, 0 = read |
| io_addr | input | 5 | Byte offset within the window |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data (combinational) |
| hp_valid | input | 1 | Hot-add event strobe |
| hp_apic_id | input | 8 | ID of the processor being added |
| gpe_sts_w1c | input | 1 | Software write of 1 to the event status flag |
| gpe_irq | output | 1 | One-cycle event interrupt pulse |
| gpe_sts | output | 1 | Sticky event status flag (event bit 2) |
| modern_mode | output | 1 | Sticky request to use the newer interface |

## Verification
The bitmap is driven with directed hot-adds at ID 0, at a mid ID, at the last valid ID and at the first invalid ID, followed by a random mix of IDs. Repeated and out-of-range IDs show whether the interrupt fires only on a newly set bit. Random writes with every data value except the switch pattern show that the bitmap and the mode cannot be changed that way. The switch pattern at offset 4 and a clear arriving in the same cycle as an event separate the exact decode and the set-wins priority from nearby wrong versions.

// File: rtl/cpuhp_pkg.sv
`timescale 1ns/1ps
package cpuhp_pkg;

    localparam int MAX_CPUS       = 256;
    localparam int WIN_BYTES      = MAX_CPUS / 8;
    localparam int ADDR_W         = $clog2(WIN_BYTES);
    localparam int ID_W           = $clog2(MAX_CPUS);
    localparam int SWITCH_BYTES   = 4;

    typedef logic [ID_W-1:0]   apic_id_t;
    typedef logic [ADDR_W-1:0] win_addr_t;

    typedef struct packed {
        logic      en;
        logic      we;
        win_addr_t addr;
        logic [7:0] wdata;
    } io_req_t;

    typedef struct packed {
        logic     valid;
        apic_id_t id;
    } hp_evt_t;

    typedef enum logic {
        MODE_LEGACY = 1'b0,
        MODE_MODERN = 1'b1
    } if_mode_e;

    function automatic logic is_read(io_req_t r);
        return r.en && !r.we;
    endfunction

    function automatic logic is_switch_req(io_req_t r);
        return r.en && r.we && (int'(r.addr) < SWITCH_BYTES) && (r.wdata == 8'h00);
    endfunction

endpackage

// File: rtl/presence_store.sv
`timescale 1ns/1ps
module presence_store
    import cpuhp_pkg::*;
#(
    parameter int NUM_CPUS = 64
) (
    input  logic                clk,
    input  logic                rst,
    input  hp_evt_t             evt,
    output logic [NUM_CPUS-1:0] present,
    output logic                newly_set
);
    logic [NUM_CPUS-1:0] hit;

    generate
        for (genvar i = 0; i < NUM_CPUS; i++) begin : g_bit
            assign hit[i] = evt.valid && (evt.id == ID_W'(i));
            if (i == 0) begin : g_boot
                assign present[i] = 1'b1;
            end else begin : g_hot
                always_ff @(posedge clk) begin
                    if (rst)
                        present[i] <= 1'b0;
                    else if (hit[i])
                        present[i] <= 1'b1;
                end
            end
        end
    endgenerate

    assign newly_set = |(hit & ~present);

endmodule

// File: rtl/byte_read_mux.sv
`timescale 1ns/1ps
module byte_read_mux
    import cpuhp_pkg::*;
#(
    parameter int NUM_CPUS = 64
) (
    input  logic [NUM_CPUS-1:0] present,
    input  win_addr_t           addr,
    output logic [7:0]          rbyte
);
    logic [MAX_CPUS-1:0] padded;
    logic [7:0]          lanes [WIN_BYTES];

    always_comb begin
        padded                 = '0;
        padded[NUM_CPUS-1:0]   = present;
    end

    generate
        for (genvar b = 0; b < WIN_BYTES; b++) begin : g_lane
            assign lanes[b] = padded[b*8 +: 8];
        end
    endgenerate

    assign rbyte = lanes[addr];

endmodule

// File: rtl/mode_detect.sv
`timescale 1ns/1ps
module mode_detect
    import cpuhp_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  io_req_t req,
    output logic    modern
);
    if_mode_e state;

    always_ff @(posedge clk) begin
        if (rst)
            state <= MODE_LEGACY;
        else if (is_switch_req(req))
            state <= MODE_MODERN;
    end

    assign modern = (state == MODE_MODERN);

endmodule

// File: rtl/gpe_event.sv
`timescale 1ns/1ps
module gpe_event (
    input  logic clk,
    input  logic rst,
    input  logic fire,
    input  logic clr,
    output logic irq,
    output logic sts
);
    always_ff @(posedge clk) begin
        if (rst) begin
            irq <= 1'b0;
            sts <= 1'b0;
        end else begin
            irq <= fire;
            if (fire)
                sts <= 1'b1;
            else if (clr)
                sts <= 1'b0;
        end
    end
endmodule

// File: rtl/cpu_present_port.sv
`timescale 1ns/1ps
module cpu_present_port
    import cpuhp_pkg::*;
#(
    parameter int NUM_CPUS = 64
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       io_en,
    input  logic       io_we,
    input  logic [4:0] io_addr,
    input  logic [7:0] io_wdata,
    output logic [7:0] io_rdata,
    input  logic       hp_valid,
    input  logic [7:0] hp_apic_id,
    input  logic       gpe_sts_w1c,
    output logic       gpe_irq,
    output logic       gpe_sts,
    output logic       modern_mode
);
    io_req_t             req;
    hp_evt_t             evt;
    logic [NUM_CPUS-1:0] present;
    logic                newly_set;
    logic [7:0]          rbyte;

    assign req = '{en: io_en, we: io_we, addr: io_addr, wdata: io_wdata};
    assign evt = '{valid: hp_valid, id: hp_apic_id};

    presence_store #(.NUM_CPUS(NUM_CPUS)) u_store (
        .clk       (clk),
        .rst       (rst),
        .evt       (evt),
        .present   (present),
        .newly_set (newly_set)
    );

    byte_read_mux #(.NUM_CPUS(NUM_CPUS)) u_mux (
        .present (present),
        .addr    (req.addr),
        .rbyte   (rbyte)
    );

    mode_detect u_mode (
        .clk    (clk),
        .rst    (rst),
        .req    (req),
        .modern (modern_mode)
    );

    gpe_event u_gpe (
        .clk  (clk),
        .rst  (rst),
        .fire (newly_set),
        .clr  (gpe_sts_w1c),
        .irq  (gpe_irq),
        .sts  (gpe_sts)
    );

    assign io_rdata = (is_read(req) && !modern_mode) ? rbyte : 8'h00;

endmodule

// File: rtl/cpu_present_port_chk.sv
`timescale 1ns/1ps
module cpu_present_port_chk #(
    parameter int NUM_CPUS = 64
) (
    input logic       clk,
    input logic       rst,
    input logic       io_en,
    input logic       io_we,
    input logic [4:0] io_addr,
    input logic [7:0] io_rdata,
    input logic       hp_valid,
    input logic       gpe_irq,
    input logic       gpe_sts,
    input logic       modern_mode
);
    assert_boot_bit_R3: assert property (@(posedge clk) disable iff (rst)
        (io_en && !io_we && !modern_mode && io_addr == 5'd0) |-> io_rdata[0]);

    assert_idle_zero_R2: assert property (@(posedge clk) disable iff (rst)
        !(io_en && !io_we) |-> io_rdata == 8'h00);

    assert_high_bytes_zero_R5: assert property (@(posedge clk) disable iff (rst)
        (int'(io_addr) * 8 >= NUM_CPUS) |-> io_rdata == 8'h00);

    assert_mode_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        modern_mode |=> modern_mode);

    assert_silent_window_R8: assert property (@(posedge clk) disable iff (rst)
        modern_mode |-> io_rdata == 8'h00);

    assert_irq_cause_R9: assert property (@(posedge clk) disable iff (rst)
        !hp_valid |=> !gpe_irq);

    assert_sts_with_irq_R10: assert property (@(posedge clk) disable iff (rst)
        gpe_irq |-> gpe_sts);
endmodule

bind cpu_present_port cpu_present_port_chk #(.NUM_CPUS(NUM_CPUS)) u_chk (.*);

// File: tb/cpu_present_port_tb.sv
`timescale 1ns/1ps
module cpu_present_port_tb;
    localparam int NC = 64;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       io_en = 1'b0, io_we = 1'b0;
    logic [4:0] io_addr = '0;
    logic [7:0] io_wdata = '0;
    logic [7:0] io_rdata;
    logic       hp_valid = 1'b0;
    logic [7:0] hp_apic_id = '0;
    logic       gpe_sts_w1c = 1'b0;
    logic       gpe_irq, gpe_sts, modern_mode;

    int n_chk = 0;
    int n_fail = 0;

    logic [255:0] exp_map;
    logic         exp_mode;
    logic         exp_sts;

    cpu_present_port #(.NUM_CPUS(NC)) u_dut (.*);

    always #2 clk = ~clk;

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_byte(int a);
        return exp_mode ? 8'h00 : exp_map[a*8 +: 8];
    endfunction

    task automatic do_read(int a, string tag);
        @(negedge clk);
        io_en = 1'b1; io_we = 1'b0; io_addr = 5'(a);
        #1;
        chk(tag, io_rdata, exp_byte(a));
        io_en = 1'b0;
    endtask

    task automatic do_write(int a, logic [7:0] d);
        @(negedge clk);
        io_en = 1'b1; io_we = 1'b1; io_addr = 5'(a); io_wdata = d;
        @(negedge clk);
        io_en = 1'b0; io_we = 1'b0;
        if (a < 4 && d == 8'h00) exp_mode = 1'b1;
        chk("R7 mode after write", {7'd0, modern_mode}, {7'd0, exp_mode});
    endtask

    task automatic do_hotadd(int id, string tag);
        logic e;
        e = (id < NC) && !exp_map[id];
        @(negedge clk);
        hp_valid = 1'b1; hp_apic_id = 8'(id);
        @(negedge clk);
        hp_valid = 1'b0;
        if (e) begin
            exp_map[id] = 1'b1;
            exp_sts = 1'b1;
        end
        chk(tag, {7'd0, gpe_irq}, {7'd0, e});
        chk("R10 sts after event", {7'd0, gpe_sts}, {7'd0, exp_sts});
    endtask

    task automatic do_clear();
        @(negedge clk);
        gpe_sts_w1c = 1'b1;
        @(negedge clk);
        gpe_sts_w1c = 1'b0;
        exp_sts = 1'b0;
        chk("R10 clear", {7'd0, gpe_sts}, 8'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        exp_map = '0; exp_map[0] = 1'b1;
        exp_mode = 1'b0; exp_sts = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R1 reset state
        chk("R1 irq", {7'd0, gpe_irq}, 8'd0);
        chk("R1 sts", {7'd0, gpe_sts}, 8'd0);
        chk("R1 mode", {7'd0, modern_mode}, 8'd0);
        for (int a = 0; a < 32; a++) do_read(a, "R1 reset bytes");
        // R2 idle data
        #1 chk("R2 idle rdata", io_rdata, 8'h00);

        // R3 boot id: no pulse
        do_hotadd(0, "R3 boot hotadd");
        do_read(0, "R3 byte0");

        // R4 / R9 set a bit
        do_hotadd(5, "R9 new bit pulse");
        do_read(0, "R4 byte0 after id5");
        @(negedge clk);
        chk("R9 pulse single cycle", {7'd0, gpe_irq}, 8'd0);
        do_hotadd(5, "R9 repeat no pulse");
        do_hotadd(NC - 1, "R9 last id");
        do_read((NC - 1) / 8, "R4 top byte");

        // R5 out of range
        do_hotadd(NC, "R5 first invalid id");
        do_hotadd(200, "R5 large id");
        do_read(NC / 8, "R5 byte past count");
        do_read(25, "R5 byte 25");

        // R6 writes leave map; R7 near-miss patterns
        do_write(0, 8'hFF);
        do_read(0, "R6 byte0 after write");
        do_write(4, 8'h00);
        do_read(0, "R6 byte0 after offset4 zero");
        do_write(7, 8'h00);

        // R10 clear and set-wins
        do_clear();
        @(negedge clk);
        hp_valid = 1'b1; hp_apic_id = 8'd10; gpe_sts_w1c = 1'b1;
        @(negedge clk);
        hp_valid = 1'b0; gpe_sts_w1c = 1'b0;
        exp_map[10] = 1'b1; exp_sts = 1'b1;
        chk("R10 set wins", {7'd0, gpe_sts}, 8'd1);
        do_read(1, "R4 byte1 id10");

        // random mix
        for (int i = 0; i < 400; i++) begin
            int op;
            op = int'($urandom_range(0, 9));
            if (op < 4) begin
                int id;
                id = ($urandom_range(0, 7) == 0) ? int'($urandom_range(0, 255))
                                                : int'($urandom_range(0, NC + 8));
                do_hotadd(id, "R9 random hotadd");
            end else if (op < 7) begin
                do_read(int'($urandom_range(0, 31)), "R2 random read");
            end else if (op < 9) begin
                int a;
                logic [7:0] d;
                a = int'($urandom_range(0, 31));
                d = 8'($urandom_range(0, 255));
                if (a < 4 && d == 8'h00) d = 8'h01;
                do_write(a, d);
            end else begin
                do_clear();
            end
        end
        for (int a = 0; a < 32; a++) do_read(a, "R6 map after random");

        // R7 switch then R8 silence
        do_write(2, 8'h00);
        chk("R7 switched", {7'd0, modern_mode}, 8'd1);
        do_write(9, 8'h55);
        chk("R7 sticky", {7'd0, modern_mode}, 8'd1);
        for (int a = 0; a < 8; a++) do_read(a, "R8 silent window");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule